// File: doc/BRIEF.md
# Hiccup-Mode Fault Supervisor

This block is the digital protection core of a power controller with several outputs. Its inputs are the comparator flags for each output: an over-voltage flag on the main output, one over-current flag for each switching channel, and one under-voltage flag shared by the linear regulators. Each flag is re-timed into the clock domain. The block also runs a counter that takes the place of the soft-start capacitor. Its outputs are a global inhibit, a command that forces the low-side switch on, a latched fault flag, and the soft-start ramp level with a ramp-complete indicator.

On an over-voltage the block latches a fault at once and forces the low-side switch on. An over-current, or an under-voltage once the ramp is complete, does not latch at once. The block inhibits every output, lets the ramp finish its climb, drains the ramp to zero for a fixed dwell, and then restarts the ramp. Each restart is one retry. When the retry count reaches its limit, the fault latches. The power-on reset is the only thing that clears the fault and the retry count. While the power-on reset is held, a separate early over-voltage input drives the low-side switch directly.

Top module: `hiccup_fault_sup`

## Requirements
- R1: While `rst` is high, `fault_o`=0, `ss_level_o`=0, `ss_done_o`=0 and `inhibit_o`=1. `lowside_on_o` equals `early_ov_i` during this time.
- R2: After `rst` falls, `ss_level_o` rises by one on each clock from 0. At the SS_TOP-th clock it reaches SS_TOP, and at that clock `ss_done_o` goes to 1 and stays at 1 while the level holds.
- R3: A high level on `ov_i` sets `fault_o`, `lowside_on_o` and `inhibit_o` on the third clock edge. No retry counting takes place.
- R4: While `rst` is high, `lowside_on_o` follows `early_ov_i` without a clock.
- R5: `oc_i[k]` is honoured only while `drv_i[k]` is 1. Bit k of both buses belongs to switching channel k.
- R6: When an honoured over-current arrives with the ramp complete, `inhibit_o` rises on the third edge. On the fourth edge the ramp drops to 0 and `ss_done_o` falls. The ramp then holds at 0 for DRAIN_CYC clocks. `inhibit_o` falls at the edge that restarts the charge, provided the trip has ended.
- R7: An over-current during the ramp climb raises `inhibit_o`, but the ramp keeps climbing to SS_TOP. It drains on the clock after `ss_done_o` rises.
- R8: `luv_i` is ignored while `ss_done_o` is 0. Once the ramp is complete it trips in the same way as an over-current.
- R9: The retry count rises by at most one per ramp cycle, at the start of each drain. With an over-current held, the fault latches at the RETRY_MAX-th drain start, after exactly RETRY_MAX ramp-complete pulses.
- R10: Once set, `fault_o` and `inhibit_o` stay at 1 and the ramp stays at 0. A fault caused by over-current leaves `lowside_on_o` at 0.
- R11: Retries are not forgotten between trips. Only `rst` clears the count and the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| ov_i | input | 1 | Main-output over-voltage comparator flag (asynchronous) |
| early_ov_i | input | 1 | Early over-voltage flag, used only while reset is held |
| oc_i | input | N_SW | Over-current comparator flags, one for each switching channel |
| drv_i | input | N_SW | Upper-switch drive active, one for each switching channel |
| luv_i | input | 1 | Linear-regulator under-voltage flag (asynchronous) |
| inhibit_o | output | 1 | Disables all outputs |
| lowside_on_o | output | 1 | Forces the low-side switch on |
| fault_o | output | 1 | Latched fault |
| ss_level_o | output | SS_W | Soft-start ramp level |
| ss_done_o | output | 1 | Ramp at full scale |

## Verification
Each comparator flag passes through two synchronizer flops and one state flop. For that reason, `fault_o` after an over-voltage and `inhibit_o` after a trip are due at the third clock edge after the input changes. The drain starts on the fourth edge, and the charge restarts DRAIN_CYC edges after that. The bench changes inputs on falling edges and waits a counted number of falling edges before it samples. It checks one edge early to confirm that a result has not yet arrived, and then at the due edge. For the retry limit, the bench counts ramp-complete pulses up to the fault. For blanking and the drive gating, it samples `inhibit_o` throughout the window in which a trip must not take effect.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef enum logic [1:0] {
        SS_CHARGE = 2'd0,
        SS_FULL   = 2'd1,
        SS_DRAIN  = 2'd2,
        SS_LOCK   = 2'd3
    } ss_state_e;

    typedef struct packed {
        logic full;
        logic drain;
        logic locked;
        logic go;
        logic fin;
    } ramp_evt_t;

    function automatic logic is_inhibiting(ss_state_e st);
        return (st == SS_DRAIN) || (st == SS_LOCK);
    endfunction

endpackage

// File: rtl/fsup_sync.sv
module fsup_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[b] <= 1'b0;
                stage2[b] <= 1'b0;
            end else begin
                stage1[b] <= d_i[b];
                stage2[b] <= stage1[b];
            end
        end
    end

    assign q_o = stage2;
endmodule

// File: rtl/fsup_ramp.sv
module fsup_ramp
    import fsup_pkg::*;
#(
    parameter int SS_W      = 8,
    parameter int SS_TOP    = 200,
    parameter int DRAIN_CYC = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pend_i,
    input  logic            lock_i,
    output logic [SS_W-1:0] level_o,
    output ramp_evt_t       evt_o
);
    localparam int DW = (DRAIN_CYC > 1) ? $clog2(DRAIN_CYC) : 1;
    localparam logic [SS_W-1:0] TOP_M1 = SS_W'(SS_TOP - 1);
    localparam logic [SS_W-1:0] TOP_V  = SS_W'(SS_TOP);
    localparam logic [DW-1:0]   D_LAST = DW'(DRAIN_CYC - 1);

    ss_state_e       st;
    logic [SS_W-1:0] level;
    logic [DW-1:0]   dcnt;
    logic            go;
    logic            fin;

    assign go  = (st == SS_FULL) && pend_i && !lock_i;
    assign fin = (st == SS_DRAIN) && (dcnt == D_LAST) && !lock_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= SS_CHARGE;
            level <= '0;
            dcnt  <= '0;
        end else if (lock_i) begin
            st    <= SS_LOCK;
            level <= '0;
            dcnt  <= '0;
        end else begin
            case (st)
                SS_CHARGE: begin
                    level <= level + 1'b1;
                    if (level == TOP_M1) st <= SS_FULL;
                end
                SS_FULL: begin
                    level <= TOP_V;
                    if (go) begin
                        st    <= SS_DRAIN;
                        level <= '0;
                        dcnt  <= '0;
                    end
                end
                SS_DRAIN: begin
                    level <= '0;
                    if (fin) begin
                        st   <= SS_CHARGE;
                        dcnt <= '0;
                    end else begin
                        dcnt <= dcnt + 1'b1;
                    end
                end
                default: begin
                    st    <= SS_LOCK;
                    level <= '0;
                end
            endcase
        end
    end

    assign level_o      = level;
    assign evt_o.full   = (st == SS_FULL);
    assign evt_o.drain  = (st == SS_DRAIN);
    assign evt_o.locked = (st == SS_LOCK);
    assign evt_o.go     = go;
    assign evt_o.fin    = fin;
endmodule

// File: rtl/fsup_guard.sv
module fsup_guard #(
    parameter int RETRY_MAX = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic ov_i,
    input  logic trip_i,
    input  logic go_i,
    input  logic fin_i,
    output logic pend_o,
    output logic fault_o,
    output logic ovhit_o
);
    localparam int CW = $clog2(RETRY_MAX + 1);
    localparam logic [CW-1:0] LAST_OK = CW'(RETRY_MAX - 1);
    localparam logic [CW-1:0] CAP     = CW'(RETRY_MAX);

    logic [CW-1:0] retries;
    logic          pend;
    logic          fault;
    logic          ovhit;

    always_ff @(posedge clk) begin
        if (rst) begin
            retries <= '0;
            pend    <= 1'b0;
            fault   <= 1'b0;
            ovhit   <= 1'b0;
        end else begin
            pend <= trip_i || (pend && !fin_i);
            if (ov_i) begin
                ovhit <= 1'b1;
                fault <= 1'b1;
            end
            if (go_i) begin
                if (retries != CAP) retries <= retries + 1'b1;
                if (retries >= LAST_OK) fault <= 1'b1;
            end
        end
    end

    assign pend_o  = pend;
    assign fault_o = fault;
    assign ovhit_o = ovhit;
endmodule

// File: rtl/hiccup_fault_sup.sv
module hiccup_fault_sup
    import fsup_pkg::*;
#(
    parameter int N_SW      = 2,
    parameter int SS_W      = 8,
    parameter int SS_TOP    = 200,
    parameter int DRAIN_CYC = 16,
    parameter int RETRY_MAX = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ov_i,
    input  logic            early_ov_i,
    input  logic [N_SW-1:0] oc_i,
    input  logic [N_SW-1:0] drv_i,
    input  logic            luv_i,
    output logic            inhibit_o,
    output logic            lowside_on_o,
    output logic            fault_o,
    output logic [SS_W-1:0] ss_level_o,
    output logic            ss_done_o
);
    localparam int SYW = N_SW + 2;

    logic [SYW-1:0]  raw_flags;
    logic [SYW-1:0]  syn_flags;
    logic [N_SW-1:0] oc_s;
    logic            ov_s;
    logic            luv_s;
    logic            oc_hon;
    logic            trip;
    logic            oc_pend;
    logic            fault;
    logic            ovhit;
    ramp_evt_t       revt;
    logic            ramp_full;
    logic            in_drain;

    assign raw_flags = {luv_i, ov_i, oc_i};

    fsup_sync #(.W(SYW)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_flags),
        .q_o (syn_flags)
    );

    assign oc_s  = syn_flags[N_SW-1:0];
    assign ov_s  = syn_flags[N_SW];
    assign luv_s = syn_flags[N_SW+1];

    assign ramp_full = revt.full;
    assign in_drain  = revt.drain;
    assign oc_hon    = |(oc_s & drv_i);
    assign trip      = !fault && (oc_hon || (luv_s && ramp_full));

    fsup_ramp #(
        .SS_W      (SS_W),
        .SS_TOP    (SS_TOP),
        .DRAIN_CYC (DRAIN_CYC)
    ) u_ramp (
        .clk     (clk),
        .rst     (rst),
        .pend_i  (oc_pend),
        .lock_i  (fault),
        .level_o (ss_level_o),
        .evt_o   (revt)
    );

    fsup_guard #(.RETRY_MAX(RETRY_MAX)) u_guard (
        .clk     (clk),
        .rst     (rst),
        .ov_i    (ov_s),
        .trip_i  (trip),
        .go_i    (revt.go),
        .fin_i   (revt.fin),
        .pend_o  (oc_pend),
        .fault_o (fault),
        .ovhit_o (ovhit)
    );

    assign inhibit_o    = rst || oc_pend || fault || revt.drain || revt.locked;
    assign lowside_on_o = (rst && early_ov_i) || ovhit;
    assign fault_o      = fault;
    assign ss_done_o    = ramp_full;
endmodule

// File: rtl/fsup_chk.sv
module fsup_chk #(
    parameter int SS_W   = 8,
    parameter int SS_TOP = 200
) (
    input logic            clk,
    input logic            rst,
    input logic            early_i,
    input logic            fault_i,
    input logic            inhibit_i,
    input logic            lowside_i,
    input logic            done_i,
    input logic [SS_W-1:0] level_i,
    input logic            pend_i,
    input logic            ochon_i,
    input logic            full_i,
    input logic            drain_i
);
    // R10
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        fault_i |=> fault_i);

    // R10
    fault_inhibit_chk: assert property (@(posedge clk) disable iff (rst)
        fault_i |-> inhibit_i);

    // R3
    lowside_cause_chk: assert property (@(posedge clk) disable iff (rst)
        lowside_i |-> fault_i);

    // R8
    luv_blank_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(pend_i) && !$past(full_i)) |-> $past(ochon_i));

    // R2
    done_level_chk: assert property (@(posedge clk) disable iff (rst)
        done_i |-> (level_i == SS_W'(SS_TOP)));

    // R6
    drain_zero_chk: assert property (@(posedge clk) disable iff (rst)
        drain_i |-> (level_i == '0) && inhibit_i);

    // R4
    always_comb begin
        if (rst && early_i) begin
            early_ov_chk: assert (lowside_i);
        end
    end
endmodule

bind hiccup_fault_sup fsup_chk #(.SS_W(SS_W), .SS_TOP(SS_TOP)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .early_i   (early_ov_i),
    .fault_i   (fault_o),
    .inhibit_i (inhibit_o),
    .lowside_i (lowside_on_o),
    .done_i    (ss_done_o),
    .level_i   (ss_level_o),
    .pend_i    (oc_pend),
    .ochon_i   (oc_hon),
    .full_i    (ramp_full),
    .drain_i   (in_drain)
);

// File: tb/test_hiccup_fault_sup.sv
module test_hiccup_fault_sup;
    localparam int N_SW  = 2;
    localparam int SS_W  = 8;
    localparam int TOP   = 12;
    localparam int DRAIN = 5;
    localparam int RMAX  = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ov_i = 1'b0;
    logic            early_ov_i = 1'b0;
    logic [N_SW-1:0] oc_i = '0;
    logic [N_SW-1:0] drv_i = '1;
    logic            luv_i = 1'b0;
    logic            inhibit_o, lowside_on_o, fault_o, ss_done_o;
    logic [SS_W-1:0] ss_level_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hiccup_fault_sup #(
        .N_SW(N_SW), .SS_W(SS_W), .SS_TOP(TOP), .DRAIN_CYC(DRAIN), .RETRY_MAX(RMAX)
    ) i_hiccup_fault_sup (
        .clk(clk), .rst(rst), .ov_i(ov_i), .early_ov_i(early_ov_i),
        .oc_i(oc_i), .drv_i(drv_i), .luv_i(luv_i),
        .inhibit_o(inhibit_o), .lowside_on_o(lowside_on_o), .fault_o(fault_o),
        .ss_level_o(ss_level_o), .ss_done_o(ss_done_o)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ov_i = 0; oc_i = '0; drv_i = '1; luv_i = 0; early_ov_i = 0;
        tick(3);
        rst = 1'b0;
    endtask

    task automatic oc_pulse(int ch);
        oc_i[ch] = 1'b1;
        tick(3);
        oc_i[ch] = 1'b0;
    endtask

    // R1, R4
    task automatic t_reset_state();
        @(negedge clk);
        rst = 1'b1; early_ov_i = 0;
        tick(3);
        chk("R1 fault", fault_o, 0);
        chk("R1 level", ss_level_o, 0);
        chk("R1 done", ss_done_o, 0);
        chk("R1 inhibit", inhibit_o, 1);
        chk("R1 lowside", lowside_on_o, 0);
        early_ov_i = 1; #1;
        chk("R4 early ov forces lowside", lowside_on_o, 1);
        early_ov_i = 0; #1;
        chk("R4 early ov released", lowside_on_o, 0);
    endtask

    // R2
    task automatic t_ramp();
        do_reset();
        tick(1);
        chk("R2 level after 1", ss_level_o, 1);
        chk("R2 inhibit clear", inhibit_o, 0);
        tick(TOP - 2);
        chk("R2 level before top", ss_level_o, TOP - 1);
        chk("R2 done early", ss_done_o, 0);
        tick(1);
        chk("R2 done at top", ss_done_o, 1);
        chk("R2 level top", ss_level_o, TOP);
        tick(5);
        chk("R2 level holds", ss_level_o, TOP);
    endtask

    // R3
    task automatic t_ov();
        do_reset();
        tick(TOP + 2);
        ov_i = 1;
        tick(2);
        chk("R3 fault not yet", fault_o, 0);
        tick(1);
        chk("R3 fault", fault_o, 1);
        chk("R3 lowside", lowside_on_o, 1);
        chk("R3 inhibit", inhibit_o, 1);
        ov_i = 0;
        tick(6);
        chk("R3 fault held", fault_o, 1);
    endtask

    // R6, R11
    task automatic t_oc_full_and_memory();
        do_reset();
        tick(TOP + 2);
        oc_i[0] = 1;
        tick(2);
        chk("R6 inhibit not yet", inhibit_o, 0);
        tick(1);
        chk("R6 inhibit", inhibit_o, 1);
        chk("R6 level still top", ss_level_o, TOP);
        oc_i[0] = 0;
        tick(1);
        chk("R6 drain level", ss_level_o, 0);
        chk("R6 done falls", ss_done_o, 0);
        tick(DRAIN - 1);
        chk("R6 still draining", inhibit_o, 1);
        tick(1);
        chk("R6 inhibit releases", inhibit_o, 0);
        chk("R6 level restart", ss_level_o, 0);
        tick(1);
        chk("R6 recharge", ss_level_o, 1);
        tick(TOP + 2);
        oc_pulse(0);
        tick(DRAIN + TOP + 4);
        chk("R11 no fault after two", fault_o, 0);
        tick(40);
        oc_pulse(0);
        chk("R11 no fault at inhibit", fault_o, 0);
        tick(1);
        chk("R11 third trip latches", fault_o, 1);
        chk("R10 lowside stays low", lowside_on_o, 0);
        tick(1);
        do_reset();
        tick(1);
        chk("R11 reset clears fault", fault_o, 0);
        tick(TOP + 2);
        oc_pulse(0);
        tick(1);
        chk("R11 count cleared", fault_o, 0);
    endtask

    // R5
    task automatic t_gating();
        do_reset();
        tick(TOP + 2);
        drv_i = '0;
        oc_i = '1;
        tick(8);
        chk("R5 undriven oc ignored", inhibit_o, 0);
        chk("R5 ramp undisturbed", ss_level_o, TOP);
        drv_i = 2'b10;
        tick(3);
        chk("R5 channel 1 honoured", inhibit_o, 1);
        oc_i = '0;
        drv_i = '1;
    endtask

    // R7
    task automatic t_oc_charge();
        do_reset();
        tick(2);
        oc_i[1] = 1;
        tick(3);
        oc_i[1] = 0;
        chk("R7 inhibit during climb", inhibit_o, 1);
        chk("R7 level", ss_level_o, 5);
        tick(1);
        chk("R7 keeps climbing", ss_level_o, 6);
        tick(TOP - 6);
        chk("R7 reaches top", ss_done_o, 1);
        tick(1);
        chk("R7 drains after top", ss_level_o, 0);
        chk("R7 done falls", ss_done_o, 0);
    endtask

    // R8
    task automatic t_luv();
        int bad;
        do_reset();
        luv_i = 1;
        bad = 0;
        for (int i = 0; i < TOP - 1; i++) begin
            tick(1);
            if (inhibit_o) bad++;
        end
        chk("R8 luv blanked during climb", bad, 0);
        tick(1);
        chk("R8 done", ss_done_o, 1);
        tick(1);
        chk("R8 luv trips after done", inhibit_o, 1);
        luv_i = 0;
    endtask

    // R9, R10
    task automatic t_retry_limit();
        int pulses;
        bit prev;
        int guard;
        do_reset();
        oc_i[0] = 1;
        pulses = 0; prev = 0; guard = 0;
        while (!fault_o && guard < 500) begin
            tick(1);
            if (ss_done_o && !prev) pulses++;
            prev = ss_done_o;
            guard++;
        end
        chk("R9 fault reached", fault_o, 1);
        chk("R9 done pulses before fault", pulses, RMAX);
        tick(30);
        chk("R10 fault sticky", fault_o, 1);
        chk("R10 inhibit held", inhibit_o, 1);
        chk("R10 level zero", ss_level_o, 0);
        chk("R10 lowside low for oc fault", lowside_on_o, 0);
        oc_i = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_ramp();
        t_ov();
        t_oc_full_and_memory();
        t_gating();
        t_oc_charge();
        t_luv();
        t_retry_limit();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule